// File: doc/BRIEF.md
# Flag-Generating Adder with Condition Evaluator

This block performs the four carry-chain operations of a processor integer unit (add, add with carry, subtract, subtract with borrow) on byte, word or long operands. It presents the result on its output at once, in the same cycle as its inputs. It also works out the sign, zero, half-carry, overflow, subtract and carry flags for that operation. When the update strobe is high, those flags are captured in a six-bit flag register on the rising clock edge.

A condition evaluator reads the registered flags continuously and compares them against a 4-bit condition selector. Its single taken output serves conditional jumps, calls, returns and set-on-condition operations. Add with carry and subtract with borrow take their carry-in from the registered carry flag. This lets a sequencer chain several operations into wider arithmetic.

Top module: `arith_flag_unit`

## Requirements
- R1: With opSel 0 (add) or 1 (add with carry), result equals dst + src (+ the registered carry flag for opSel 1). The sum is taken modulo the operand width chosen by opSize: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits above that width are ignored, and the result bits above it are zero.
- R2: With opSel 2 (subtract) or 3 (subtract with borrow), result equals dst − src (− the registered carry flag for opSel 3), modulo the operand width. Result bits above the width are zero.
- R3: Carry (flagsOut bit 0) is set on a carry out of the operand's top bit for add and on a borrow for subtract.
- R4: Sign (flagsOut bit 5) copies the top bit of the width-limited result. Zero (flagsOut bit 4) is set when the width-limited result is zero.
- R5: For 8- and 16-bit operations, half-carry (flagsOut bit 3) is the carry or borrow out of bit 3. It is computed on the low four bits of each operand together with the carry-in for opSel 1 and 3.
- R6: A 32-bit operation leaves half-carry at its previous value.
- R7: Overflow (flagsOut bit 2) on add is set when both operands have the same sign and the result sign differs from it. On subtract it is set when the operand signs differ and the result sign differs from the sign of dst.
- R8: The subtract flag (flagsOut bit 1) is cleared by opSel 0 and 1 and set by opSel 2 and 3.
- R9: flagsOut is zero after reset and changes only at a clock edge on which flagWr is high. With flagWr low, an operation still drives result but leaves every flag as it was.
- R10: condTaken for condCode 0..7 equals, in that order: false, S^V, Z|(S^V), C|Z, V, S, Z, C. These are evaluated on the registered flags.
- R11: condCode 8..15 give the inverse of condCode 0..7 respectively, so condCode 8 is always true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dstOp | input | 32 | Destination (left) operand |
| srcOp | input | 32 | Source (right) operand |
| opSize | input | 2 | Operand width: 0 byte, 1 word, 2/3 long |
| opSel | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| flagWr | input | 1 | Capture the new flags at the next rising edge |
| condCode | input | 4 | Condition selector for condTaken |
| result | output | 32 | Width-limited result, zero-extended |
| flagsOut | output | 6 | Registered flags {S,Z,H,V,N,C} |
| condTaken | output | 1 | Condition selector evaluated on the registered flags |

## Verification
A corrupted flag register shows up one cycle after the write, both on flagsOut and on every condition code that depends on the bad bit. The inverse code always shows the opposite answer. A wrong carry also spreads into the very next add-with-carry or subtract-with-borrow result in the same cycle it is applied. A lost hold on the half-carry shows only after a 32-bit update, so the bench deliberately places a long operation between byte operations that leave known half-carry values. A lane or size-select fault shows as nonzero upper result bits, or as a sign or carry taken from the wrong bit, as soon as operands with mixed upper bits are applied.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_LANES = 3;
  localparam int DATA_W    = BYTE_W << (NUM_LANES - 1);
  localparam int NIB_W     = 4;
  localparam int SEL_W     = $clog2(NUM_LANES);
  localparam int FLAG_W    = 6;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBC = 2'd3
  } arith_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3
  } op_size_e;

  typedef struct packed {
    logic             subtract;
    logic             carryIn;
    logic             holdHalf;
    logic             load;
    logic [SEL_W-1:0] laneSel;
  } ctrl_strobe_t;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic v;
    logic n;
    logic c;
  } flag_set_t;
endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic [1:0]   opSel,
  input  logic [1:0]   opSize,
  input  logic         flagWr,
  output ctrl_strobe_t strobe
);
  arith_op_e opKind;
  op_size_e  sizeKind;

  always_comb begin
    opKind   = arith_op_e'(opSel);
    sizeKind = op_size_e'(opSize);
    strobe.subtract = (opKind == OP_SUB) || (opKind == OP_SBC);
    strobe.carryIn  = (opKind == OP_ADC) || (opKind == OP_SBC);
    strobe.load     = flagWr;
    unique case (sizeKind)
      SZ_BYTE: strobe.laneSel = SEL_W'(0);
      SZ_WORD: strobe.laneSel = SEL_W'(1);
      default: strobe.laneSel = SEL_W'(NUM_LANES - 1);
    endcase
    strobe.holdHalf = (strobe.laneSel == SEL_W'(NUM_LANES - 1));
  end
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [DATA_W-1:0] srcOp,
  input  ctrl_strobe_t      strobe,
  output logic [DATA_W-1:0] result,
  output flag_set_t         flagReg
);
  logic              cin;
  logic [DATA_W-1:0] laneRes [NUM_LANES];
  logic              laneC   [NUM_LANES];
  logic              laneS   [NUM_LANES];
  logic              laneV   [NUM_LANES];
  logic [NIB_W:0]    nibSum;
  flag_set_t         nextFlags;

  assign cin = strobe.carryIn & flagReg.c;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int LW = BYTE_W << k;
    logic [LW-1:0] aOp;
    logic [LW-1:0] bOp;
    logic [LW:0]   ext;
    always_comb begin
      aOp = dstOp[LW-1:0];
      bOp = srcOp[LW-1:0];
      if (strobe.subtract)
        ext = {1'b0, aOp} - {1'b0, bOp} - {{LW{1'b0}}, cin};
      else
        ext = {1'b0, aOp} + {1'b0, bOp} + {{LW{1'b0}}, cin};
    end
    assign laneRes[k] = DATA_W'(ext[LW-1:0]);
    assign laneC[k]   = ext[LW];
    assign laneS[k]   = ext[LW-1];
    assign laneV[k]   = strobe.subtract
                      ? ((aOp[LW-1] != bOp[LW-1]) && (ext[LW-1] != aOp[LW-1]))
                      : ((aOp[LW-1] == bOp[LW-1]) && (ext[LW-1] != aOp[LW-1]));
  end

  always_comb begin
    if (strobe.subtract)
      nibSum = {1'b0, dstOp[NIB_W-1:0]} - {1'b0, srcOp[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
    else
      nibSum = {1'b0, dstOp[NIB_W-1:0]} + {1'b0, srcOp[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  end

  assign result = laneRes[strobe.laneSel];

  always_comb begin
    nextFlags.s = laneS[strobe.laneSel];
    nextFlags.z = (result == '0);
    nextFlags.h = strobe.holdHalf ? flagReg.h : nibSum[NIB_W];
    nextFlags.v = laneV[strobe.laneSel];
    nextFlags.n = strobe.subtract;
    nextFlags.c = laneC[strobe.laneSel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flagReg <= '0;
    else if (strobe.load) flagReg <= nextFlags;
  end

  // R1 / R2: bits above a byte-wide result stay clear
  always_comb begin
    if (rst_n && strobe.laneSel == SEL_W'(0))
      assert_upper_clear_R1: assert (result[DATA_W-1:BYTE_W] == '0);
  end

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(flagReg));

  assert_half_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.holdHalf) |=> flagReg.h == $past(flagReg.h));

  assert_sub_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> flagReg.n == $past(strobe.subtract));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> flagReg.z == ($past(result) == '0));
endmodule

// File: rtl/afu_cond.sv
module afu_cond
  import afu_pkg::*;
(
  input  logic      rst_n,
  input  flag_set_t flags,
  input  logic [3:0] condCode,
  output logic      condTaken
);
  logic signLess;
  logic baseHit;

  assign signLess = flags.s ^ flags.v;

  always_comb begin
    unique case (condCode[2:0])
      3'd0: baseHit = 1'b0;
      3'd1: baseHit = signLess;
      3'd2: baseHit = flags.z | signLess;
      3'd3: baseHit = flags.c | flags.z;
      3'd4: baseHit = flags.v;
      3'd5: baseHit = flags.s;
      3'd6: baseHit = flags.z;
      default: baseHit = flags.c;
    endcase
  end

  assign condTaken = baseHit ^ condCode[3];

  always_comb begin
    if (rst_n && condCode == 4'd8)
      assert_always_true_R11: assert (condTaken);
    if (rst_n && condCode == 4'd0)
      assert_never_true_R10: assert (!condTaken);
    if (rst_n && condCode == 4'd6)
      assert_zero_code_R10: assert (condTaken == flags.z);
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dstOp,
  input  logic [31:0] srcOp,
  input  logic [1:0]  opSize,
  input  logic [1:0]  opSel,
  input  logic        flagWr,
  input  logic [3:0]  condCode,
  output logic [31:0] result,
  output logic [5:0]  flagsOut,
  output logic        condTaken
);
  ctrl_strobe_t strobe;
  flag_set_t    flagReg;

  afu_ctrl u_ctrl (
    .opSel  (opSel),
    .opSize (opSize),
    .flagWr (flagWr),
    .strobe (strobe)
  );

  afu_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .dstOp   (dstOp),
    .srcOp   (srcOp),
    .strobe  (strobe),
    .result  (result),
    .flagReg (flagReg)
  );

  afu_cond u_cond (
    .rst_n     (rst_n),
    .flags     (flagReg),
    .condCode  (condCode),
    .condTaken (condTaken)
  );

  assign flagsOut = flagReg;
endmodule

// File: tb/arith_flag_unit_test.sv
`timescale 1ns/1ps
module arith_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dstOp = '0;
  logic [31:0] srcOp = '0;
  logic [1:0]  opSize = '0;
  logic [1:0]  opSel = '0;
  logic        flagWr = 1'b0;
  logic [3:0]  condCode = '0;
  logic [31:0] result;
  logic [5:0]  flagsOut;
  logic        condTaken;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] expFlags = '0;

  always #5 clk = ~clk;

  arith_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .dstOp(dstOp), .srcOp(srcOp), .opSize(opSize),
    .opSel(opSel), .flagWr(flagWr), .condCode(condCode), .result(result),
    .flagsOut(flagsOut), .condTaken(condTaken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference from the requirement text; flags {S,Z,H,V,N,C}
  function automatic void refModel(input logic [31:0] d, input logic [31:0] s,
      input int sz, input int op, input logic [5:0] fin,
      output logic [31:0] r, output logic [5:0] fo);
    longint mask, a, b, c, full, half;
    int msb;
    bit isSub, sa, sb, sr;
    mask = (sz == 0) ? 64'hFF : (sz == 1) ? 64'hFFFF : 64'hFFFF_FFFF;
    msb  = (sz == 0) ? 7 : (sz == 1) ? 15 : 31;
    a = longint'(d) & mask;
    b = longint'(s) & mask;
    c = (op == 1 || op == 3) ? longint'(fin[0]) : 0;
    isSub = (op >= 2);
    full = isSub ? a - b - c : a + b + c;
    half = isSub ? (a & 15) - (b & 15) - c : (a & 15) + (b & 15) + c;
    r = 32'(full & mask);
    sa = a[msb]; sb = b[msb]; sr = r[msb];
    fo[5] = sr;
    fo[4] = (r == 0);
    fo[3] = (sz >= 2) ? fin[3] : (isSub ? (half < 0) : (half > 15));
    fo[2] = isSub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    fo[1] = isSub;
    fo[0] = isSub ? (full < 0) : (full > mask);
  endfunction

  function automatic bit refCond(input logic [5:0] f, input logic [3:0] cc);
    bit s, z, v, c, hit;
    s = f[5]; z = f[4]; v = f[2]; c = f[0];
    case (cc[2:0])
      0: hit = 0;
      1: hit = s ^ v;
      2: hit = z | (s ^ v);
      3: hit = c | z;
      4: hit = v;
      5: hit = s;
      6: hit = z;
      default: hit = c;
    endcase
    return hit ^ cc[3];
  endfunction

  task automatic runOp(input logic [31:0] d, input logic [31:0] s, input int sz,
                       input int op, input bit wr);
    logic [31:0] er;
    logic [5:0]  ef;
    string rt;
    refModel(d, s, sz, op, expFlags, er, ef);
    @(negedge clk);
    dstOp = d; srcOp = s; opSize = 2'(sz); opSel = 2'(op); flagWr = wr;
    #1;
    rt = (op >= 2) ? "R2 result" : "R1 result";
    chk(rt, result, er);
    @(negedge clk);
    flagWr = 0;
    if (wr) begin
      expFlags = ef;
      chk("R4 sign", 32'(flagsOut[5]), 32'(ef[5]));
      chk("R4 zero", 32'(flagsOut[4]), 32'(ef[4]));
      if (sz >= 2) chk("R6 half held", 32'(flagsOut[3]), 32'(ef[3]));
      else         chk("R5 half", 32'(flagsOut[3]), 32'(ef[3]));
      chk("R7 overflow", 32'(flagsOut[2]), 32'(ef[2]));
      chk("R8 subtract flag", 32'(flagsOut[1]), 32'(ef[1]));
      chk("R3 carry", 32'(flagsOut[0]), 32'(ef[0]));
    end else begin
      chk("R9 flags held", 32'(flagsOut), 32'(expFlags));
    end
  endtask

  task automatic checkConds();
    for (int k = 0; k < 16; k++) begin
      condCode = 4'(k);
      #1;
      if (k < 8) chk($sformatf("R10 cond %0d", k), 32'(condTaken), 32'(refCond(expFlags, 4'(k))));
      else       chk($sformatf("R11 cond %0d", k), 32'(condTaken), 32'(refCond(expFlags, 4'(k))));
    end
  endtask

  task automatic test_reset();
    chk("R9 reset flags", 32'(flagsOut), 32'h0);
    checkConds();
  endtask

  task automatic test_add_byte();
    runOp(32'hABCD_127F, 32'h5500_0001, 0, 0, 1);   // 0x80: S,V,H
    checkConds();
    runOp(32'h0000_00FF, 32'hFFFF_FF01, 0, 0, 1);   // 0x00: Z,C,H
    checkConds();
    runOp(32'h0000_0080, 32'h0000_0080, 0, 0, 1);   // signed overflow to zero
  endtask

  task automatic test_adc_word();
    runOp(32'h0000_FFFF, 32'h0000_0001, 1, 0, 1);   // sets C
    runOp(32'h1234_00FF, 32'h0000_0000, 1, 1, 1);   // 0x0100 via carry-in
    runOp(32'h0000_7FFF, 32'h0000_0000, 1, 1, 1);   // C now 0
  endtask

  task automatic test_sub();
    runOp(32'h0000_0000, 32'h0000_0001, 0, 2, 1);   // borrow, C=1
    runOp(32'h0000_0010, 32'h0000_000F, 0, 3, 1);   // 0x10-0x0F-1 = 0
    runOp(32'h0000_0080, 32'h0000_0001, 0, 2, 1);   // V on subtract
    checkConds();
    runOp(32'h8000_0000, 32'h0000_0001, 1, 2, 1);   // word, upper ignored
    runOp(32'h0000_0000, 32'h0000_0001, 2, 2, 1);   // long borrow
    runOp(32'h0000_0005, 32'h0000_0002, 2, 3, 1);   // long with borrow-in
    checkConds();
  endtask

  task automatic test_half_long();
    runOp(32'h0000_000F, 32'h0000_0001, 0, 0, 1);   // H=1
    runOp(32'h0000_0010, 32'h0000_0010, 2, 0, 1);   // long, no nibble carry: H stays 1
    runOp(32'h0000_0001, 32'h0000_0001, 0, 0, 1);   // H=0
    runOp(32'h7FFF_FFFF, 32'h0000_0001, 3, 0, 1);   // long via size 3, nibble carry: H stays 0
    checkConds();
  endtask

  task automatic test_hold();
    runOp(32'h0000_00FF, 32'h0000_0001, 0, 0, 0);   // result only
    runOp(32'h0000_0000, 32'h0000_0009, 1, 2, 0);
    checkConds();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_add_byte();
    test_adc_word();
    test_sub();
    test_half_long();
    test_hold();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule